// File: doc/BRIEF.md
# Multi-Source Event Queue with Host Attention Line

The block collects event notifications from several on-chip IP blocks and hands them to an external host one word at a time. Each source presents an instance number, a channel number and an event number with a valid strobe. A round-robin arbiter picks one source per cycle and the block packs the three fields into a 32-bit event word, which goes into a single first-in first-out queue. When the queue is full, every source is held off, so no event is ever lost. A sticky flag records that some source had to wait because the queue was full.

A registered attention line tells the host that events are waiting. The host pops one word per read strobe through a separate read port, for example a debug-bridge register. The word appears on the next cycle. The host keeps reading until the attention line falls. Reading while the queue is empty returns zero and does not disturb the queue.

The queue's fill state is an occupancy state machine with three states: `Q_EMPTY`, `Q_PARTIAL` and `Q_FULL`. Its transitions are:
- `Q_EMPTY` to `Q_PARTIAL` on a push.
- `Q_PARTIAL` to `Q_FULL` on a push that fills the last slot.
- `Q_PARTIAL` to `Q_EMPTY` on a pop of the last word.
- `Q_FULL` to `Q_PARTIAL` on a pop.

A push and a pop in the same cycle from `Q_PARTIAL` leave the state unchanged. The arbiter holds a rotating priority pointer that moves to the source after the last winner.

Top module: `evt_queue_attn`

## Requirements
- R1: A stored event word holds the source's instance number in bits 31:24, its channel in bits 23:12 and its event number in bits 11:0.
- R2: Words leave the queue in the order in which they were accepted. A post is accepted in a cycle where both the valid and the ready bit of that source are high.
- R3: At most one ready bit is high in any cycle, and only for a source whose valid bit is high. The ready bit goes to the first requesting source at or after the priority pointer, searching upward and wrapping from the last source to source 0. After an accepted post the pointer moves to the source after the winner.
- R4: While the queue holds DEPTH words, every ready bit is low. A waiting source keeps its request until it is accepted, so nothing is dropped.
- R5: The overflow output goes high in the cycle after any valid bit is high while the queue is full. It stays high until reset.
- R6: A read strobe in one cycle produces the popped word on the read data output in the next cycle, with the read-valid output high for exactly that cycle.
- R7: A read strobe while the queue is empty returns all zeros and leaves the queue contents and occupancy unchanged.
- R8: The attention output is high exactly when the queue holds at least one word. It rises in the cycle after the first accepted post and falls in the cycle after the final pop.
- R9: A post and a read in the same cycle on an empty queue return zero and store the posted word. A read on a full queue pops one word and accepts no post in that cycle, leaving DEPTH-1 words.
- R10: After reset the ready bits, attention, overflow, read-valid and read data are all low, and the priority pointer is at source 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NUM_SRC | Per-source post request |
| src_inst | input | NUM_SRC*8 | Per-source instance number, source i at bits [8i+7:8i] |
| src_chan | input | NUM_SRC*12 | Per-source channel number, source i at bits [12i+11:12i] |
| src_evt | input | NUM_SRC*12 | Per-source event number, source i at bits [12i+11:12i] |
| src_ready | output | NUM_SRC | Per-source acceptance, one-hot or zero |
| rd_req | input | 1 | Host read strobe, pops one word |
| rd_data | output | 32 | Popped event word, zero for an empty read |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| attn | output | 1 | Host attention: queue not empty |
| overflow | output | 1 | Sticky: a post was attempted while full |

## Verification
The bench builds the block with three sources and a queue depth of four. Three sources make the wrap of the priority pointer a non-power-of-two case. A depth of four means the queue reaches the full state within a few cycles of random traffic, so back-pressure, the overflow flag and a read while full occur many times. Directed sequences also reach an empty-queue read, a post and a read in the same cycle on an empty queue, and a read on a full queue.

// File: rtl/evt_q_pkg.sv
package evt_q_pkg;

    localparam int INST_W = 8;
    localparam int CHAN_W = 12;
    localparam int EVT_W  = 12;
    localparam int WORD_W = INST_W + CHAN_W + EVT_W;

    typedef logic [WORD_W-1:0] evt_word_t;

    // occupancy of the queue
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } q_state_e;

    // effective operation in one cycle
    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } q_op_e;

    function automatic evt_word_t pack_evt(
        input logic [INST_W-1:0] inst,
        input logic [CHAN_W-1:0] chan,
        input logic [EVT_W-1:0]  evt
    );
        return {inst, chan, evt};
    endfunction

endpackage

// File: rtl/evt_rr_arb.sv
module evt_rr_arb #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req,
    input  logic                 en,
    output logic [N-1:0]         gnt,
    output logic [IDX_W-1:0]     gnt_idx,
    output logic                 gnt_any
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

    logic [IDX_W-1:0] prio_ptr;

    // search upward from the pointer, wrapping at N
    always_comb begin
        int cand;
        gnt     = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        cand    = 0;
        if (en) begin
            for (int off = 0; off < N; off++) begin
                cand = int'(prio_ptr) + off;
                if (cand >= N) begin
                    cand = cand - N;
                end
                if (!gnt_any && req[cand]) begin
                    gnt_any = 1'b1;
                    gnt_idx = IDX_W'(cand);
                end
            end
        end
        if (gnt_any) begin
            gnt[gnt_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_ptr <= '0;
        end else if (gnt_any) begin
            prio_ptr <= (gnt_idx == LAST) ? '0 : gnt_idx + IDX_W'(1);
        end
    end

endmodule

// File: rtl/evt_fifo.sv
module evt_fifo
    import evt_q_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  evt_word_t        push_data,
    input  logic             pop,
    output evt_word_t        head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty,
    output logic             nonempty_nxt
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] LVL_ONE  = LW'(1);
    localparam logic [LW-1:0] LVL_TOP  = LW'(DEPTH - 1);

    q_state_e  st_q, st_d;
    q_op_e     op;
    evt_word_t mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    // operation actually performed this cycle
    always_comb begin
        logic do_push, do_pop;
        do_push = push && (st_q != Q_FULL);
        do_pop  = pop  && (st_q != Q_EMPTY);
        unique case ({do_push, do_pop})
            2'b10:   op = OP_PUSH;
            2'b01:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= Q_EMPTY;
        end else begin
            st_q <= st_d;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            Q_EMPTY: begin
                if (op == OP_PUSH) st_d = Q_PARTIAL;
            end
            Q_PARTIAL: begin
                if (op == OP_PUSH && level == LVL_TOP) st_d = Q_FULL;
                else if (op == OP_POP && level == LVL_ONE) st_d = Q_EMPTY;
            end
            Q_FULL: begin
                if (op == OP_POP) st_d = Q_PARTIAL;
            end
            default: st_d = Q_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full         = (st_q == Q_FULL);
        empty        = (st_q == Q_EMPTY);
        nonempty_nxt = (st_d != Q_EMPTY);
        head         = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            unique case (op)
                OP_PUSH: level <= level + LVL_ONE;
                OP_POP:  level <= level - LVL_ONE;
                default: level <= level;
            endcase
            if (op == OP_PUSH || op == OP_SWAP) begin
                wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + AW'(1);
            end
            if (op == OP_POP || op == OP_SWAP) begin
                rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + AW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (op == OP_PUSH || op == OP_SWAP) begin
            mem[wr_ptr] <= push_data;
        end
    end

endmodule

// File: rtl/evt_queue_attn.sv
module evt_queue_attn
    import evt_q_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int DEPTH   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         src_valid,
    input  logic [NUM_SRC*INST_W-1:0]  src_inst,
    input  logic [NUM_SRC*CHAN_W-1:0]  src_chan,
    input  logic [NUM_SRC*EVT_W-1:0]   src_evt,
    output logic [NUM_SRC-1:0]         src_ready,
    input  logic                       rd_req,
    output logic [WORD_W-1:0]          rd_data,
    output logic                       rd_valid,
    output logic                       attn,
    output logic                       overflow
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam int LW    = $clog2(DEPTH + 1);

    evt_word_t        src_word [NUM_SRC];
    logic [IDX_W-1:0] win_idx;
    logic             win_any;
    logic             q_full, q_empty, q_nonempty_nxt;
    logic [LW-1:0]    q_level;
    evt_word_t        q_head;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pack
        assign src_word[g] = pack_evt(src_inst[g*INST_W +: INST_W],
                                      src_chan[g*CHAN_W +: CHAN_W],
                                      src_evt[g*EVT_W +: EVT_W]);
    end

    evt_rr_arb #(.N(NUM_SRC)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_valid),
        .en      (!q_full),
        .gnt     (src_ready),
        .gnt_idx (win_idx),
        .gnt_any (win_any)
    );

    evt_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .push         (win_any),
        .push_data    (src_word[win_idx]),
        .pop          (rd_req),
        .head         (q_head),
        .level        (q_level),
        .full         (q_full),
        .empty        (q_empty),
        .nonempty_nxt (q_nonempty_nxt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            attn     <= 1'b0;
            overflow <= 1'b0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) begin
                rd_data <= q_empty ? '0 : q_head;
            end
            attn     <= q_nonempty_nxt;
            overflow <= overflow | (q_full & (|src_valid));
        end
    end

endmodule

// File: rtl/evt_queue_attn_chk.sv
module evt_queue_attn_chk #(
    parameter int NUM_SRC = 4,
    parameter int DEPTH   = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   src_valid,
    input logic [NUM_SRC-1:0]   src_ready,
    input logic                 rd_req,
    input logic [31:0]          rd_data,
    input logic                 rd_valid,
    input logic                 attn,
    input logic                 overflow,
    input logic [$clog2(DEPTH+1)-1:0] lvl
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    a_r3_ready_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_ready));

    a_r3_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (src_ready & ~src_valid) == '0);

    a_r4_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == FULL_LVL) |-> (src_ready == '0));

    a_r4_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        lvl <= FULL_LVL);

    a_r5_overflow_set: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl == FULL_LVL && (|src_valid)) |=> overflow);

    a_r5_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    a_r6_valid_only_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    a_r7_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && lvl == '0) |=> (rd_data == '0));

    a_r8_attn_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
        attn == (lvl != '0));

    a_r9_full_read_drops_one: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && lvl == FULL_LVL) |=> (lvl == LW'(DEPTH - 1)));

endmodule

bind evt_queue_attn evt_queue_attn_chk #(.NUM_SRC(NUM_SRC), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_valid (src_valid),
    .src_ready (src_ready),
    .rd_req    (rd_req),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .attn      (attn),
    .overflow  (overflow),
    .lvl       (q_level)
);

// File: tb/tb_evt_queue_attn.sv
module tb_evt_queue_attn;
    localparam int NS = 3;
    localparam int DP = 4;

    logic              clk;
    logic              rst_n;
    logic [NS-1:0]     src_valid;
    logic [NS*8-1:0]   src_inst;
    logic [NS*12-1:0]  src_chan;
    logic [NS*12-1:0]  src_evt;
    logic [NS-1:0]     src_ready;
    logic              rd_req;
    logic [31:0]       rd_data;
    logic              rd_valid;
    logic              attn;
    logic              overflow;

    evt_queue_attn #(.NUM_SRC(NS), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_inst(src_inst),
        .src_chan(src_chan), .src_evt(src_evt), .src_ready(src_ready),
        .rd_req(rd_req), .rd_data(rd_data), .rd_valid(rd_valid),
        .attn(attn), .overflow(overflow)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // reference model state
    logic [31:0] mq [DP];
    int          mcnt = 0;
    int          mptr = 0;
    logic        movf = 1'b0;

    function automatic void check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endfunction

    // R1: instance in 31:24, channel in 23:12, event in 11:0
    function automatic logic [31:0] bpack(input int i);
        return {src_inst[i*8 +: 8], src_chan[i*12 +: 12], src_evt[i*12 +: 12]};
    endfunction

    function automatic void randomize_src(input int i);
        src_inst[i*8 +: 8]   = 8'($urandom);
        src_chan[i*12 +: 12] = 12'($urandom);
        src_evt[i*12 +: 12]  = 12'($urandom);
    endfunction

    // one cycle: entered just after a falling edge
    task automatic cycle(input logic [NS-1:0] v, input logic rd, output logic [NS-1:0] acc);
        logic [NS-1:0] eg;
        logic [31:0]   pw;
        logic [31:0]   mrd;
        int            g;
        bit            was_empty;
        src_valid = v;
        rd_req    = rd;
        #2;
        eg = '0;
        g  = -1;
        pw = '0;
        if (mcnt < DP) begin
            for (int k = 0; k < NS; k++) begin
                int c = (mptr + k) % NS;
                if (g < 0 && v[c]) g = c;
            end
        end
        if (g >= 0) begin
            eg[g] = 1'b1;
            pw = bpack(g);
        end
        check(mcnt == DP ? "R4 ready held low while full" : "R3 round-robin ready",
              32'(src_ready), 32'(eg));
        @(posedge clk);
        if (mcnt == DP && (|v)) movf = 1'b1;
        was_empty = (mcnt == 0);
        mrd = '0;
        if (rd && mcnt > 0) begin
            mrd = mq[0];
            for (int k = 0; k < DP - 1; k++) mq[k] = mq[k+1];
            mcnt--;
        end
        if (g >= 0) begin
            mq[mcnt] = pw;
            mcnt++;
            mptr = (g + 1) % NS;
        end
        #1;
        check("R8 attention level", 32'(attn), 32'(mcnt != 0));
        check("R5 overflow flag", 32'(overflow), 32'(movf));
        check("R6 read valid", 32'(rd_valid), 32'(rd));
        if (rd) begin
            if (was_empty) check("R7 empty read zero", rd_data, 32'h0);
            else           check("R2 order and R1 packing", rd_data, mrd);
        end
        acc = eg;
        @(negedge clk);
    endtask

    task automatic run(input int n, input int vpct, input int rpct);
        logic [NS-1:0] pend, v, acc;
        pend = '0;
        for (int t = 0; t < n; t++) begin
            v = pend;
            for (int i = 0; i < NS; i++) begin
                if (!pend[i]) begin
                    v[i] = (($urandom % 100) < vpct);
                    randomize_src(i);
                end
            end
            cycle(v, (($urandom % 100) < rpct), acc);
            pend = v & ~acc;  // R4: waiting source keeps its request
        end
    endtask

    initial begin
        logic [NS-1:0] acc;
        void'($urandom(32'd4711));
        rst_n = 1'b0;
        src_valid = '0; rd_req = 1'b0;
        src_inst = '0; src_chan = '0; src_evt = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        check("R10 attn after reset", 32'(attn), 32'h0);
        check("R10 overflow after reset", 32'(overflow), 32'h0);
        check("R10 rd_valid after reset", 32'(rd_valid), 32'h0);
        check("R10 rd_data after reset", rd_data, 32'h0);
        check("R10 ready after reset", 32'(src_ready), 32'h0);
        // R7: empty read
        cycle('0, 1'b1, acc);
        for (int i = 0; i < NS; i++) randomize_src(i);
        // R3: all three at once, pointer starts at 0 (R10)
        cycle(3'b111, 1'b0, acc);
        cycle(3'b110, 1'b0, acc);
        cycle(3'b100, 1'b0, acc);
        randomize_src(0);
        cycle(3'b001, 1'b0, acc);   // now full
        // R4/R5: posts while full
        randomize_src(1);
        cycle(3'b011, 1'b0, acc);
        // R9: read on full, no post accepted
        cycle(3'b011, 1'b1, acc);
        cycle(3'b011, 1'b0, acc);
        // drain: R8 falls after last pop
        repeat (DP + 1) cycle('0, 1'b1, acc);
        // R9: post and read together on empty
        randomize_src(2);
        cycle(3'b100, 1'b1, acc);
        cycle('0, 1'b1, acc);
        // random traffic: light reading, then heavy reading
        run(3000, 60, 25);
        run(3000, 40, 75);
        run(2000, 70, 50);
        repeat (DP + 1) cycle('0, 1'b1, acc);
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

endmodule